// File: doc/BRIEF.md
# Vibration Lockout and Fault Supervisor

This block decides whether a gear-tooth sensor's switching output may toggle. An upstream stage measures the peak-to-peak span of the processed signal and presents it with a valid strobe. When that span drops under a low level, the activity is treated as vibration and switching is blanked. Switching comes back only once the span climbs above a higher level. Spans that fall between the two levels leave the current state unchanged.

An undervoltage flag overrides everything. It raises a force-high request and holds switching off until the flag clears. A watchdog counts timebase ticks since the most recent output edge. If no edge arrives for a set number of ticks, it emits a one-clock recalibration reset, and that reset also returns the amplitude gate to its locked state.

Top module: `switch_guard`

## Requirements
- R1: After reset the gate is locked, and `sw_en`, `force_hi` and `recal` are all 0.
- R2: When `span_vld` is 1 and `span` < `LOE_LVL` (unsigned compare), the gate locks. `sw_en` is 0 from the second rising edge after the strobe.
- R3: When `span_vld` is 1 and `span` > `REL_LVL`, the gate opens. A strobed span with `LOE_LVL` <= `span` <= `REL_LVL` leaves the gate state unchanged.
- R4: `span` has no effect while `span_vld` is 0.
- R5: `sw_en` is 1 exactly when the gate is open and no undervoltage is registered. It updates two rising edges after the strobe edge.
- R6: Two edges after `uv_flag` is sampled 1, `force_hi` is 1 and `sw_en` is 0. Both return to their normal values two edges after `uv_flag` is sampled 0.
- R7: `recal` is a single-clock pulse. It is raised on the edge where the `WD_LIMIT`-th `tick` with no `edge_pulse` is sampled, and the tick count then restarts from zero.
- R8: `edge_pulse` clears the tick count. If `edge_pulse` and `tick` arrive in the same cycle, the clear wins and that tick is not counted.
- R9: A `recal` pulse locks the gate, so `sw_en` is 0 on the following cycle. It stays 0 until a strobed span exceeds `REL_LVL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| span | input | SPAN_W | Peak-to-peak amplitude, in sample LSBs |
| span_vld | input | 1 | Strobe marking `span` as valid |
| uv_flag | input | 1 | Undervoltage indication |
| edge_pulse | input | 1 | One pulse per raw output edge |
| tick | input | 1 | Watchdog timebase pulse |
| sw_en | output | 1 | Output switching allowed |
| force_hi | output | 1 | Force the output to its high state |
| recal | output | 1 | One-clock full recalibration reset |

## Verification
The gate state is registered on the edge that samples the strobe, and `sw_en` is registered one edge after that. The bench therefore drives inputs on falling edges and samples `sw_en` at the falling edge that follows the second rising edge. Undervoltage has the same two-edge latency.

`recal` becomes visible at the falling edge immediately after the tick that reaches the limit. Its effect on `sw_en` appears one cycle later, so each watchdog check samples at those points. The bench sweeps every span value from both the locked and the open state, and compares each result against a gate model kept in the bench.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic {
    GATE_OPEN   = 1'b0,
    GATE_LOCKED = 1'b1
  } gate_t;
endpackage

// File: rtl/sg_amp_gate.sv
module sg_amp_gate
  import sg_pkg::*;
#(
  parameter int SPAN_W  = 10,
  parameter int LOE_LVL = 170,
  parameter int REL_LVL = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SPAN_W-1:0] span,
  input  logic              span_vld,
  input  logic              relock,
  output logic              locked
);
  localparam logic [SPAN_W-1:0] LoeCmp = SPAN_W'(LOE_LVL);
  localparam logic [SPAN_W-1:0] RelCmp = SPAN_W'(REL_LVL);

  gate_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (relock) begin
      state_d = GATE_LOCKED;
    end else if (span_vld) begin
      if (state_q == GATE_LOCKED && span > RelCmp) state_d = GATE_OPEN;
      else if (state_q == GATE_OPEN && span < LoeCmp) state_d = GATE_LOCKED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= GATE_LOCKED;
    else     state_q <= state_d;
  end

  assign locked = (state_q == GATE_LOCKED);
endmodule

// File: rtl/sg_watchdog.sv
module sg_watchdog #(
  parameter int WD_LIMIT = 65535
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_pulse,
  input  logic tick,
  output logic fire,
  output logic recal
);
  localparam int CntW = (WD_LIMIT > 1) ? $clog2(WD_LIMIT) : 1;
  localparam logic [CntW-1:0] LastCnt = CntW'(WD_LIMIT - 1);

  logic [CntW-1:0] cnt_q;
  logic            recal_q;

  assign fire = tick && !edge_pulse && (cnt_q == LastCnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      recal_q <= 1'b0;
    end else begin
      recal_q <= fire;
      if (edge_pulse || fire) cnt_q <= '0;
      else if (tick)          cnt_q <= cnt_q + 1'b1;
    end
  end

  assign recal = recal_q;
endmodule

// File: rtl/sg_out_stage.sv
module sg_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic uv_flag,
  input  logic locked,
  output logic sw_en,
  output logic force_hi
);
  logic uv_q, en_q, force_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_q    <= 1'b0;
      en_q    <= 1'b0;
      force_q <= 1'b0;
    end else begin
      uv_q    <= uv_flag;
      force_q <= uv_q;
      en_q    <= !locked && !uv_q;
    end
  end

  assign sw_en    = en_q;
  assign force_hi = force_q;
endmodule

// File: rtl/switch_guard.sv
module switch_guard #(
  parameter int SPAN_W   = 10,
  parameter int LOE_LVL  = 170,
  parameter int REL_LVL  = 200,
  parameter int WD_LIMIT = 65535
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SPAN_W-1:0] span,
  input  logic              span_vld,
  input  logic              uv_flag,
  input  logic              edge_pulse,
  input  logic              tick,
  output logic              sw_en,
  output logic              force_hi,
  output logic              recal
);
  logic wd_fire;
  logic gate_locked;

  sg_watchdog #(.WD_LIMIT(WD_LIMIT)) u_wd (
    .clk(clk), .rst(rst), .edge_pulse(edge_pulse), .tick(tick),
    .fire(wd_fire), .recal(recal)
  );

  sg_amp_gate #(.SPAN_W(SPAN_W), .LOE_LVL(LOE_LVL), .REL_LVL(REL_LVL)) u_gate (
    .clk(clk), .rst(rst), .span(span), .span_vld(span_vld),
    .relock(wd_fire), .locked(gate_locked)
  );

  sg_out_stage u_out (
    .clk(clk), .rst(rst), .uv_flag(uv_flag), .locked(gate_locked),
    .sw_en(sw_en), .force_hi(force_hi)
  );
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int SPAN_W  = 10,
  parameter int LOE_LVL = 170
) (
  input logic              clk,
  input logic              rst,
  input logic [SPAN_W-1:0] span,
  input logic              span_vld,
  input logic              uv_flag,
  input logic              edge_pulse,
  input logic              sw_en,
  input logic              force_hi,
  input logic              recal
);
  AST_LOW_SPAN_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (span_vld && span < SPAN_W'(LOE_LVL)) |=> ##1 !sw_en); // R2
  AST_UV_FORCES_HIGH: assert property (@(posedge clk) disable iff (rst)
    uv_flag |=> ##1 force_hi); // R6
  AST_FORCE_BLOCKS_EN: assert property (@(posedge clk) disable iff (rst)
    force_hi |-> !sw_en); // R6
  AST_RECAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    recal |=> !recal); // R7
  AST_EDGE_NO_RECAL: assert property (@(posedge clk) disable iff (rst)
    edge_pulse |=> !recal); // R8
  AST_RECAL_RELOCKS: assert property (@(posedge clk) disable iff (rst)
    recal |=> !sw_en); // R9
endmodule

bind switch_guard sg_checker #(.SPAN_W(SPAN_W), .LOE_LVL(LOE_LVL)) u_chk (
  .clk(clk), .rst(rst), .span(span), .span_vld(span_vld), .uv_flag(uv_flag),
  .edge_pulse(edge_pulse), .sw_en(sw_en), .force_hi(force_hi), .recal(recal)
);

// File: tb/switch_guard_tb.sv
module switch_guard_tb;
  localparam int SW = 5;
  localparam int LOE = 10;
  localparam int REL = 13;
  localparam int WD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] span = '0;
  logic span_vld = 1'b0, uv_flag = 1'b0, edge_pulse = 1'b0, tick = 1'b0;
  logic sw_en, force_hi, recal;
  int n_run = 0, n_fail = 0;
  bit exp_locked;

  always #10 clk = ~clk;

  switch_guard #(.SPAN_W(SW), .LOE_LVL(LOE), .REL_LVL(REL), .WD_LIMIT(WD)) u_dut (
    .clk(clk), .rst(rst), .span(span), .span_vld(span_vld), .uv_flag(uv_flag),
    .edge_pulse(edge_pulse), .tick(tick), .sw_en(sw_en), .force_hi(force_hi),
    .recal(recal)
  );

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic strobe(input int v);
    @(negedge clk); span = SW'(v); span_vld = 1'b1;
    @(negedge clk); span_vld = 1'b0;
    @(negedge clk);
    if (exp_locked && v > REL) exp_locked = 1'b0;
    else if (!exp_locked && v < LOE) exp_locked = 1'b1;
  endtask

  task automatic do_tick(input bit with_edge);
    @(negedge clk); tick = 1'b1; edge_pulse = with_edge;
    @(negedge clk); tick = 1'b0; edge_pulse = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run finished)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_locked = 1'b1;
    @(negedge clk);
    check("R1 sw_en", int'(sw_en), 0);
    check("R1 force_hi", int'(force_hi), 0);
    check("R1 recal", int'(recal), 0);

    // R2 R3 R5: every span from each starting state
    for (int st = 0; st < 2; st++) begin
      for (int v = 0; v < (1 << SW); v++) begin
        strobe(st == 0 ? 0 : (1 << SW) - 1);
        strobe(v);
        check(v < LOE ? "R2 lock" : "R3 open/hold", int'(sw_en), int'(!exp_locked));
      end
    end

    // R4: span without strobe ignored
    strobe(31);
    @(negedge clk); span = '0;
    repeat (3) @(negedge clk);
    check("R4 open kept", int'(sw_en), 1);
    strobe(0);
    @(negedge clk); span = 5'd31;
    repeat (3) @(negedge clk);
    check("R4 locked kept", int'(sw_en), 0);

    // R6: undervoltage override
    strobe(31);
    @(negedge clk); uv_flag = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 force_hi", int'(force_hi), 1);
    check("R6 sw_en off", int'(sw_en), 0);
    @(negedge clk); uv_flag = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R6 force released", int'(force_hi), 0);
    check("R6 sw_en back", int'(sw_en), 1);

    // R7 R9: watchdog expiry
    do_tick(1'b1);
    for (int i = 1; i <= WD; i++) begin
      do_tick(1'b0);
      check("R7 recal at limit", int'(recal), int'(i == WD));
    end
    @(negedge clk);
    check("R7 single pulse", int'(recal), 0);
    check("R9 relock", int'(sw_en), 0);
    exp_locked = 1'b1;
    strobe(REL);
    check("R9 stays locked", int'(sw_en), 0);
    strobe(REL + 1);
    check("R9 reopen", int'(sw_en), 1);

    // R8: edge clears, wins over tick
    for (int i = 1; i < WD; i++) do_tick(1'b0);
    do_tick(1'b1);
    check("R8 edge no recal", int'(recal), 0);
    for (int i = 1; i <= WD; i++) begin
      do_tick(1'b0);
      check("R8 recount", int'(recal), int'(i == WD));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule